// File: doc/BRIEF.md
# Two-Bank Interleaved Cache Line Store

This block holds the data half of a cache: a set of eight-word lines spread over two 32-bit single-port RAM banks. Words with an even index inside the line live in the even bank and words with an odd index live in the odd bank. Because of this split, one aligned word pair sits at the same address in both banks, and a 64-bit read port can return two words per cycle. When a request needs only one word, only the bank that holds it is enabled and the other bank stays idle.

Three kinds of request reach the store: reads of one word or an aligned pair, stores of one word or an aligned pair, and line refills. A refill begins with a start strobe that names the line. Four data beats then follow, one word pair per beat, in rising pair order. A one-cycle done pulse comes after the last beat. Tag lookup, hit detection and the memory bus sit outside this block.

Top module: `pairbank_cache_ram`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid`, `err_misalign` and `fill_done` are low and `rd_data` is zero.
- R2: Word index w (0..7) of a line is stored in the even bank when w[0]=0 and in the odd bank when w[0]=1. A single-word read or write asserts only that bank's enable output, in the request cycle.
- R3: A pair read (`rd_pair`=1, even `rd_word`) enables both banks. One cycle later it returns word w in `rd_data[31:0]` and word w+1 in `rd_data[63:32]`.
- R4: A single-word read returns an even word in `rd_data[31:0]` and an odd word in `rd_data[63:32]`. The other half of the bus reads zero.
- R5: A single-word write stores `wr_data[31:0]` for an even word and `wr_data[63:32]` for an odd word. The other lane of `wr_data` is ignored and the neighbouring word keeps its value.
- R6: A pair write with even `wr_word` stores `wr_data[31:0]` to word w and `wr_data[63:32]` to word w+1, enabling both banks.
- R7: A pair read or pair write with odd `rd_word`/`wr_word` enables no bank, writes nothing and returns no data. `err_misalign` is high in the next cycle.
- R8: After `fill_start` names a line, each of the next four `fill_valid` beats writes `fill_data[31:0]`/`fill_data[63:32]` to words 2p/2p+1 of that line for beat p=0..3, enabling both banks.
- R9: `fill_done` is high for exactly one cycle, the cycle after the fourth refill beat.
- R10: `fill_valid` with no refill in progress writes nothing and enables no bank. `fill_start` during a refill is ignored, and the remaining beats still target the first line.
- R11: `rd_valid` is high exactly in the cycle after an accepted read, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_pair | input | 1 | Read two words (1) or one word (0) |
| rd_line | input | LINE_W | Line index for the read |
| rd_word | input | 3 | Word index inside the line for the read |
| wr_en | input | 1 | Store request |
| wr_pair | input | 1 | Store two words (1) or one word (0) |
| wr_line | input | LINE_W | Line index for the store |
| wr_word | input | 3 | Word index inside the line for the store |
| wr_data | input | 64 | Store data, even lane low, odd lane high |
| fill_start | input | 1 | Begin a line refill |
| fill_line | input | LINE_W | Line index for the refill |
| fill_valid | input | 1 | Refill beat carrying one word pair |
| fill_data | input | 64 | Refill pair, even word low |
| rd_data | output | 64 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data is valid |
| err_misalign | output | 1 | Misaligned pair request seen in the previous cycle |
| fill_done | output | 1 | Refill finished |
| bank_en_even | output | 1 | Even bank enabled this cycle |
| bank_en_odd | output | 1 | Odd bank enabled this cycle |

## Verification
The assertions assume the surrounding cache issues at most one of `rd_en`, `wr_en` and `fill_valid` per cycle. This reflects the single port on each bank. With that assumption, `rd_valid` follows only from a read and not from a request that lost on priority. The stimulus tasks each drive exactly one request per cycle and clear the others, and the bench feeds a stray refill beat only in a cycle that carries no read or store. Line and word indices stay within the line range the bench has refilled, so no read returns uninitialised storage.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int PAIRS      = LINE_WORDS / 2;
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int PIDX_W     = $clog2(PAIRS);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_FILL  = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        logic en_even;
        logic en_odd;
        logic we;
        logic misalign;
    } bank_req_t;

    function automatic logic word_is_odd(input logic [WIDX_W-1:0] w);
        return w[0];
    endfunction

    function automatic logic [PIDX_W-1:0] pair_of(input logic [WIDX_W-1:0] w);
        return w[WIDX_W-1:1];
    endfunction

    function automatic logic pair_misaligned(input logic pair, input logic [WIDX_W-1:0] w);
        return pair & w[0];
    endfunction

endpackage

// File: rtl/cbr_bank.sv
module cbr_bank #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/cbr_fill.sv
module cbr_fill
    import cbr_pkg::*;
#(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_start,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_valid,
    output logic              beat,
    output logic [LINE_W-1:0] beat_line,
    output logic [PIDX_W-1:0] beat_pair,
    output logic              done
);

    localparam logic [PIDX_W-1:0] LAST_PAIR = PIDX_W'(PAIRS - 1);

    logic              busy_q;
    logic [PIDX_W-1:0] cnt_q;
    logic [LINE_W-1:0] line_q;
    logic              done_q;

    assign beat      = busy_q && fill_valid;
    assign beat_line = line_q;
    assign beat_pair = cnt_q;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            line_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && fill_start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                line_q <= fill_line;
            end else if (beat) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST_PAIR) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
#(
    parameter int LINE_W = 6,
    localparam int AW    = LINE_W + PIDX_W
) (
    input  logic              rd_en,
    input  logic              rd_pair,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [WIDX_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic              wr_pair,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [2*WORD_W-1:0] wr_data,
    input  logic              fill_beat,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [PIDX_W-1:0] fill_pair,
    input  logic [2*WORD_W-1:0] fill_data,
    output bank_req_t         req,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] wdata_even,
    output logic [WORD_W-1:0] wdata_odd
);

    always_comb begin
        req        = '0;
        req.op     = OP_IDLE;
        addr       = '0;
        wdata_even = '0;
        wdata_odd  = '0;
        if (fill_beat) begin
            req.op      = OP_FILL;
            req.we      = 1'b1;
            req.en_even = 1'b1;
            req.en_odd  = 1'b1;
            addr        = {fill_line, fill_pair};
            wdata_even  = fill_data[WORD_W-1:0];
            wdata_odd   = fill_data[2*WORD_W-1:WORD_W];
        end else if (wr_en) begin
            if (pair_misaligned(wr_pair, wr_word)) begin
                req.misalign = 1'b1;
            end else begin
                req.op      = OP_WRITE;
                req.we      = 1'b1;
                req.en_even = wr_pair || !word_is_odd(wr_word);
                req.en_odd  = wr_pair ||  word_is_odd(wr_word);
                addr        = {wr_line, pair_of(wr_word)};
                wdata_even  = wr_data[WORD_W-1:0];
                wdata_odd   = wr_data[2*WORD_W-1:WORD_W];
            end
        end else if (rd_en) begin
            if (pair_misaligned(rd_pair, rd_word)) begin
                req.misalign = 1'b1;
            end else begin
                req.op      = OP_READ;
                req.en_even = rd_pair || !word_is_odd(rd_word);
                req.en_odd  = rd_pair ||  word_is_odd(rd_word);
                addr        = {rd_line, pair_of(rd_word)};
            end
        end
    end

endmodule

// File: rtl/pairbank_cache_ram.sv
module pairbank_cache_ram
    import cbr_pkg::*;
#(
    parameter int LINES   = 64,
    localparam int LINE_W = $clog2(LINES),
    localparam int AW     = LINE_W + PIDX_W,
    localparam int DEPTH  = LINES * PAIRS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic                rd_pair,
    input  logic [LINE_W-1:0]   rd_line,
    input  logic [WIDX_W-1:0]   rd_word,
    input  logic                wr_en,
    input  logic                wr_pair,
    input  logic [LINE_W-1:0]   wr_line,
    input  logic [WIDX_W-1:0]   wr_word,
    input  logic [2*WORD_W-1:0] wr_data,
    input  logic                fill_start,
    input  logic [LINE_W-1:0]   fill_line,
    input  logic                fill_valid,
    input  logic [2*WORD_W-1:0] fill_data,
    output logic [2*WORD_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                err_misalign,
    output logic                fill_done,
    output logic                bank_en_even,
    output logic                bank_en_odd
);

    logic              beat;
    logic [LINE_W-1:0] beat_line;
    logic [PIDX_W-1:0] beat_pair;
    bank_req_t         req;
    logic [AW-1:0]     addr;
    logic [WORD_W-1:0] wdata [2];
    logic [WORD_W-1:0] rdata [2];
    logic              lane_q [2];
    logic              valid_q;
    logic              err_q;

    cbr_fill #(.LINE_W(LINE_W)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .fill_start (fill_start),
        .fill_line  (fill_line),
        .fill_valid (fill_valid),
        .beat       (beat),
        .beat_line  (beat_line),
        .beat_pair  (beat_pair),
        .done       (fill_done)
    );

    cbr_decode #(.LINE_W(LINE_W)) u_dec (
        .rd_en      (rd_en),
        .rd_pair    (rd_pair),
        .rd_line    (rd_line),
        .rd_word    (rd_word),
        .wr_en      (wr_en),
        .wr_pair    (wr_pair),
        .wr_line    (wr_line),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .fill_beat  (beat),
        .fill_line  (beat_line),
        .fill_pair  (beat_pair),
        .fill_data  (fill_data),
        .req        (req),
        .addr       (addr),
        .wdata_even (wdata[0]),
        .wdata_odd  (wdata[1])
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic en_b;
        assign en_b = (b == 0) ? req.en_even : req.en_odd;

        cbr_bank #(.DEPTH(DEPTH), .W(WORD_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .en    (en_b),
            .we    (req.we),
            .addr  (addr),
            .wdata (wdata[b]),
            .rdata (rdata[b])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[b] <= 1'b0;
            end else begin
                lane_q[b] <= en_b && (req.op == OP_READ);
            end
        end

        assign rd_data[b*WORD_W +: WORD_W] = lane_q[b] ? rdata[b] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= (req.op == OP_READ);
            err_q   <= req.misalign;
        end
    end

    assign rd_valid     = valid_q;
    assign err_misalign = err_q;
    assign bank_en_even = req.en_even;
    assign bank_en_odd  = req.en_odd;

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        rd_pair,
    input logic [2:0]  rd_word,
    input logic        wr_en,
    input logic        wr_pair,
    input logic [2:0]  wr_word,
    input logic        fill_valid,
    input logic [63:0] rd_data,
    input logic        rd_valid,
    input logic        err_misalign,
    input logic        fill_done,
    input logic        bank_en_even,
    input logic        bank_en_odd
);

    // input assumption: one request of any kind per cycle
    a_in_one_request: assert property (@(posedge clk) disable iff (rst)
        $countones({rd_en, wr_en, fill_valid}) <= 1);

    // R2
    a_r2_single_read_one_bank: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_pair) |-> ($countones({bank_en_even, bank_en_odd}) == 1
                                 && bank_en_odd == rd_word[0]));

    // R3
    a_r3_pair_read_both: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_pair && !rd_word[0]) |-> (bank_en_even && bank_en_odd));

    // R4
    a_r4_even_lane_zero_hi: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(!rd_pair && !rd_word[0])) |-> (rd_data[63:32] == 32'h0));

    a_r4_odd_lane_zero_lo: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(!rd_pair && rd_word[0])) |-> (rd_data[31:0] == 32'h0));

    // R5
    a_r5_single_write_one_bank: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_pair) |-> ($countones({bank_en_even, bank_en_odd}) == 1
                                 && bank_en_odd == wr_word[0]));

    // R6
    a_r6_pair_write_both: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_pair && !wr_word[0]) |-> (bank_en_even && bank_en_odd));

    // R7
    a_r7_misaligned_no_bank: assert property (@(posedge clk) disable iff (rst)
        ((rd_en && rd_pair && rd_word[0]) || (wr_en && wr_pair && wr_word[0]))
        |-> (!bank_en_even && !bank_en_odd));

    a_r7_error_flag: assert property (@(posedge clk) disable iff (rst)
        ((rd_en && rd_pair && rd_word[0]) || (wr_en && wr_pair && wr_word[0]))
        |=> err_misalign);

    // R9
    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !fill_done);

    // R11
    a_r11_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(rd_pair && rd_word[0])) |=> rd_valid);

    a_r11_no_valid_without_read: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

bind pairbank_cache_ram cbr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .rd_pair      (rd_pair),
    .rd_word      (rd_word),
    .wr_en        (wr_en),
    .wr_pair      (wr_pair),
    .wr_word      (wr_word),
    .fill_valid   (fill_valid),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .err_misalign (err_misalign),
    .fill_done    (fill_done),
    .bank_en_even (bank_en_even),
    .bank_en_odd  (bank_en_odd)
);

// File: tb/sim_pairbank_cache_ram.sv
module sim_pairbank_cache_ram;

    localparam int LINES = 64;
    localparam int LW    = $clog2(LINES);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en, rd_pair, wr_en, wr_pair, fill_start, fill_valid;
    logic [LW-1:0] rd_line, wr_line, fill_line;
    logic [2:0]  rd_word, wr_word;
    logic [63:0] wr_data, fill_data, rd_data;
    logic        rd_valid, err_misalign, fill_done, bank_en_even, bank_en_odd;

    always #5 clk = ~clk;

    pairbank_cache_ram #(.LINES(LINES)) u0 (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_pair(rd_pair), .rd_line(rd_line), .rd_word(rd_word),
        .wr_en(wr_en), .wr_pair(wr_pair), .wr_line(wr_line), .wr_word(wr_word),
        .wr_data(wr_data),
        .fill_start(fill_start), .fill_line(fill_line), .fill_valid(fill_valid),
        .fill_data(fill_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .err_misalign(err_misalign),
        .fill_done(fill_done), .bank_en_even(bank_en_even), .bank_en_odd(bank_en_odd)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_e = 0, exp_o = 0, got_e = 0, got_o = 0;
    logic [63:0] expq [$];
    logic [31:0] model [8][8];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops expected read data (R3, R4, R11)
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (expq.size() == 0) chk("R11 rd_valid without read", 64'd1, 64'd0);
            else chk("R3/R4 read data", rd_data, expq.pop_front());
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            got_e += int'(bank_en_even);
            got_o += int'(bank_en_odd);
        end
    end

    task automatic clr();
        rd_en = 0; rd_pair = 0; rd_line = '0; rd_word = '0;
        wr_en = 0; wr_pair = 0; wr_line = '0; wr_word = '0; wr_data = '0;
        fill_start = 0; fill_line = '0; fill_valid = 0; fill_data = '0;
    endtask

    task automatic idle();
        @(negedge clk);
        clr();
    endtask

    task automatic rd(input int line, input int word, input bit pair);
        bit bad, ee, eo;
        @(negedge clk);
        clr();
        rd_en = 1; rd_pair = pair; rd_line = LW'(line); rd_word = 3'(word);
        #1;
        bad = pair && word[0];
        ee = !bad && (pair || !word[0]);
        eo = !bad && (pair || word[0]);
        exp_e += int'(ee); exp_o += int'(eo);
        chk(pair ? "R3 pair read enables" : (bad ? "R7 read enables" : "R2 read enables"),
            {62'd0, bank_en_even, bank_en_odd}, {62'd0, ee, eo});
        if (!bad) begin
            if (pair) expq.push_back({model[line][word+1], model[line][word]});
            else if (word[0]) expq.push_back({model[line][word], 32'h0});
            else expq.push_back({32'h0, model[line][word]});
        end else begin
            @(negedge clk);
            clr();
            chk("R7 err after misaligned read", {63'd0, err_misalign}, 64'd1);
        end
    endtask

    task automatic wr(input int line, input int word, input bit pair, input logic [63:0] d);
        bit bad, ee, eo;
        @(negedge clk);
        clr();
        wr_en = 1; wr_pair = pair; wr_line = LW'(line); wr_word = 3'(word); wr_data = d;
        #1;
        bad = pair && word[0];
        ee = !bad && (pair || !word[0]);
        eo = !bad && (pair || word[0]);
        exp_e += int'(ee); exp_o += int'(eo);
        chk(pair ? (bad ? "R7 write enables" : "R6 write enables") : "R5 write enables",
            {62'd0, bank_en_even, bank_en_odd}, {62'd0, ee, eo});
        if (!bad) begin
            if (pair) begin
                model[line][word]   = d[31:0];
                model[line][word+1] = d[63:32];
            end else begin
                model[line][word] = word[0] ? d[63:32] : d[31:0];
            end
        end else begin
            @(negedge clk);
            clr();
            chk("R7 err after misaligned write", {63'd0, err_misalign}, 64'd1);
        end
    endtask

    task automatic fill(input int line, input int seed, input bit intrude);
        logic [31:0] d [8];
        for (int i = 0; i < 8; i++) d[i] = 32'(seed) * 32'h01000193 + 32'(line * 16 + i);
        @(negedge clk);
        clr();
        fill_start = 1; fill_line = LW'(line);
        #1;
        chk("R8 start enables no bank", {62'd0, bank_en_even, bank_en_odd}, 64'd0);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            clr();
            fill_valid = 1;
            fill_data = {d[2*p+1], d[2*p]};
            if (intrude && p == 1) begin
                fill_start = 1; fill_line = LW'(line ^ 1);
            end
            #1;
            exp_e++; exp_o++;
            chk("R8 beat enables both banks", {62'd0, bank_en_even, bank_en_odd}, 64'd3);
            chk("R9 no done during beats", {63'd0, fill_done}, 64'd0);
        end
        @(negedge clk);
        clr();
        chk("R9 done after last beat", {63'd0, fill_done}, 64'd1);
        @(negedge clk);
        chk("R9 done one cycle only", {63'd0, fill_done}, 64'd0);
        for (int i = 0; i < 8; i++) model[line][i] = d[i];
    endtask

    task automatic read_line(input int line);
        for (int w = 0; w < 8; w++) rd(line, w, 1'b0);
        for (int w = 0; w < 8; w += 2) rd(line, w, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 64'd1, 64'd0);
        summary();
    end

    initial begin
        clr();
        rst = 1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 rd_valid in reset", {63'd0, rd_valid}, 64'd0);
        chk("R1 rd_data in reset", rd_data, 64'd0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 rd_valid after reset", {63'd0, rd_valid}, 64'd0);
        chk("R1 err after reset", {63'd0, err_misalign}, 64'd0);
        chk("R1 fill_done after reset", {63'd0, fill_done}, 64'd0);
        chk("R1 rd_data after reset", rd_data, 64'd0);

        // R8, R9: refill eight lines; R10: intrusion on line 3
        for (int l = 0; l < 8; l++) fill(l, 7, l == 3);

        // R2, R3, R4, R11: back-to-back single and pair reads
        read_line(0);
        read_line(3);
        for (int w = 0; w < 8; w += 2) rd(1, w, 1'b1);

        // R7: misaligned pair read
        rd(2, 3, 1'b1);
        rd(2, 2, 1'b1);

        // R5: single writes with junk in the unused lane
        wr(4, 2, 1'b0, 64'hDEAD_BEEF_1111_2222);
        wr(4, 5, 1'b0, 64'h3333_4444_BAD0_BAD0);
        // R6: aligned pair write
        wr(4, 6, 1'b1, 64'h6666_7777_8888_9999);
        // R7: misaligned pair write leaves line 5 untouched
        wr(5, 1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        read_line(4);
        read_line(5);

        // R10: stray refill beat with no refill in progress
        @(negedge clk);
        clr();
        fill_valid = 1; fill_data = 64'hA5A5_A5A5_A5A5_A5A5;
        #1;
        chk("R10 stray beat enables no bank", {62'd0, bank_en_even, bank_en_odd}, 64'd0);
        read_line(0);

        // R8: refill over earlier writes
        fill(4, 21, 1'b0);
        read_line(4);
        read_line(2);

        idle(); idle(); idle();
        chk("R2 even bank enable count", 64'(got_e), 64'(exp_e));
        chk("R2 odd bank enable count", 64'(got_o), 64'(exp_o));
        chk("R11 all reads returned", 64'(expq.size()), 64'd0);
        summary();
    end

endmodule